// File: doc/BRIEF.md
# Nybble Accumulator Processor

This block is a small processor core with one 4-bit accumulator. It fetches 4-bit opcodes and operand nybbles from a 256-word memory of 4-bit words over a synchronous memory port. It executes eight defined instructions: load, store, conditional jump, increment, decrement, no-operation, show-on-LEDs and blank-LEDs. Its only output besides the memory port is a 4-bit LED register.

An instruction with an address operand takes the two nybbles that follow its opcode as one 8-bit address, high nybble first. The program counter steps past both. The memory returns read data one cycle after the address is presented, and it writes on the clock edge where write enable is high.

Instructions without an operand take two cycles. Store and jump take seven cycles, and load takes eight.

Top module: `nyb_cpu`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `led` is 0, `mem_we` is 0 and `mem_addr` is 0. The program counter and the accumulator also restart from 0.
- R2: Opcode 0x0 and the unassigned opcodes 0x8 to 0xF advance the program counter by one. They leave the accumulator, the LEDs and the memory untouched.
- R3: Opcode 0x1 followed by nybbles H, L loads the accumulator from address {H,L}. H is the upper four address bits.
- R4: Opcode 0x2 followed by H, L writes the accumulator to address {H,L}. `mem_we` is high for exactly one cycle.
- R5: Opcode 0x3 followed by H, L continues execution at {H,L} when the accumulator is 0.
- R6: Opcode 0x3 with a non-zero accumulator continues at the word after its second operand nybble.
- R7: Opcode 0x4 increments the accumulator modulo 16, so 15 becomes 0.
- R8: Opcode 0x5 decrements the accumulator modulo 16, so 0 becomes 15.
- R9: Opcode 0x6 copies the accumulator to `led`. `led` otherwise holds its value while the accumulator changes.
- R10: Opcode 0x7 sets `led` to 0.
- R11: An instruction without an operand completes two cycles after its opcode is addressed. After reset, the third such instruction updates `led` on the sixth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory word address |
| mem_rdata | input | 4 | Read data, valid one cycle after the address |
| mem_wdata | output | 4 | Write data (the accumulator) |
| mem_we | output | 1 | Write enable |
| led | output | 4 | LED display register |

## Verification
The bench builds the core with its default parameters: 4-bit words and 8-bit addresses. Each operand is therefore exactly two nybbles. Swapped nybble order shows up as a load from, or a store to, a distinct address. The 4-bit width puts both accumulator wrap points within a few instructions, and the full 256-word space lets every program end in a load from the top word followed by a self-jump.

// File: rtl/nyb_pkg.sv
package nyb_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_NOP   = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_JZERO = 4'h3;
  localparam logic [OPC_W-1:0] OPC_INCR  = 4'h4;
  localparam logic [OPC_W-1:0] OPC_DECR  = 4'h5;
  localparam logic [OPC_W-1:0] OPC_SHOW  = 4'h6;
  localparam logic [OPC_W-1:0] OPC_BLANK = 4'h7;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_OPND_REQ,
    ST_OPND_CAP,
    ST_EXEC,
    ST_LOAD
  } nyb_state_e;

  typedef enum logic [1:0] {
    ACC_HOLD,
    ACC_INC,
    ACC_DEC,
    ACC_LOAD
  } acc_op_e;

  typedef enum logic [1:0] {
    LED_HOLD,
    LED_SHOW,
    LED_BLANK
  } led_op_e;

  typedef enum logic {
    ASEL_PC,
    ASEL_OPND
  } addr_sel_e;

  function automatic logic takes_operand(input logic [OPC_W-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_JZERO);
  endfunction

endpackage

// File: rtl/nyb_ctrl.sv
module nyb_ctrl
  import nyb_pkg::*;
#(
  parameter int OPND_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc,
  input  logic             acc_zero,
  output acc_op_e          acc_op,
  output led_op_e          led_op,
  output addr_sel_e        addr_sel,
  output logic             pc_inc,
  output logic             pc_load,
  output logic             opnd_shift,
  output logic             store_we
);

  localparam int CNT_W = (OPND_N > 1) ? $clog2(OPND_N) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OPND_N - 1);

  nyb_state_e       state_q, state_d;
  logic [OPC_W-1:0] ir_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_opnd;

  assign last_opnd = (cnt_q == CNT_LAST);

  always_comb begin
    state_d    = state_q;
    acc_op     = ACC_HOLD;
    led_op     = LED_HOLD;
    addr_sel   = ASEL_PC;
    pc_inc     = 1'b0;
    pc_load    = 1'b0;
    opnd_shift = 1'b0;
    store_we   = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        pc_inc = 1'b1;
        if (takes_operand(opc)) begin
          state_d = ST_OPND_REQ;
        end else begin
          state_d = ST_FETCH;
          case (opc)
            OPC_INCR:  acc_op = ACC_INC;
            OPC_DECR:  acc_op = ACC_DEC;
            OPC_SHOW:  led_op = LED_SHOW;
            OPC_BLANK: led_op = LED_BLANK;
            default:   ;
          endcase
        end
      end
      ST_OPND_REQ: begin
        state_d = ST_OPND_CAP;
      end
      ST_OPND_CAP: begin
        opnd_shift = 1'b1;
        pc_inc     = 1'b1;
        state_d    = last_opnd ? ST_EXEC : ST_OPND_REQ;
      end
      ST_EXEC: begin
        addr_sel = ASEL_OPND;
        state_d  = ST_FETCH;
        case (ir_q)
          OPC_LOAD:  state_d = ST_LOAD;
          OPC_STORE: store_we = 1'b1;
          OPC_JZERO: pc_load = acc_zero;
          default:   ;
        endcase
      end
      ST_LOAD: begin
        acc_op  = ACC_LOAD;
        state_d = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      ir_q    <= OPC_NOP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DECODE) begin
        ir_q <= opc;
      end
      if (state_q == ST_OPND_CAP) begin
        cnt_q <= last_opnd ? '0 : cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/nyb_pcu.sv
module nyb_pcu #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_inc,
  input  logic              pc_load,
  input  logic              opnd_shift,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] opnd
);

  localparam int OPND_N = ADDR_W / DATA_W;

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] cur);
    return cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (pc_load) begin
      pc <= opnd;
    end else if (pc_inc) begin
      pc <= seq_next(pc);
    end
  end

  generate
    if (OPND_N == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          opnd <= '0;
        end else if (opnd_shift) begin
          opnd <= ADDR_W'(rdata);
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          opnd <= '0;
        end else if (opnd_shift) begin
          opnd <= {opnd[ADDR_W-DATA_W-1:0], rdata};
        end
      end
    end
  endgenerate

endmodule

// File: rtl/nyb_acc.sv
module nyb_acc
  import nyb_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_op_e           acc_op,
  input  led_op_e           led_op,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] led,
  output logic              acc_zero
);

  function automatic logic [DATA_W-1:0] wrap_up(input logic [DATA_W-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] wrap_down(input logic [DATA_W-1:0] v);
    return v - 1'b1;
  endfunction

  assign acc_zero = (acc == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else begin
      unique case (acc_op)
        ACC_INC:  acc <= wrap_up(acc);
        ACC_DEC:  acc <= wrap_down(acc);
        ACC_LOAD: acc <= rdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led <= '0;
    end else begin
      unique case (led_op)
        LED_SHOW:  led <= acc;
        LED_BLANK: led <= '0;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/nyb_cpu.sv
module nyb_cpu
  import nyb_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] led
);

  localparam int OPND_N = ADDR_W / DATA_W;

  acc_op_e           acc_op;
  led_op_e           led_op;
  addr_sel_e         addr_sel;
  logic              pc_inc, pc_load, opnd_shift, store_we;
  logic [ADDR_W-1:0] pc_q, opnd_q;
  logic [DATA_W-1:0] acc_q;
  logic              acc_zero;
  logic [OPC_W-1:0]  opc;

  // named events for the checker
  logic evt_inc, evt_dec, evt_load, evt_show, evt_blank, evt_jump;

  assign opc = mem_rdata[OPC_W-1:0];

  nyb_ctrl #(.OPND_N(OPND_N)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .opc        (opc),
    .acc_zero   (acc_zero),
    .acc_op     (acc_op),
    .led_op     (led_op),
    .addr_sel   (addr_sel),
    .pc_inc     (pc_inc),
    .pc_load    (pc_load),
    .opnd_shift (opnd_shift),
    .store_we   (store_we)
  );

  nyb_pcu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pcu (
    .clk        (clk),
    .rst        (rst),
    .pc_inc     (pc_inc),
    .pc_load    (pc_load),
    .opnd_shift (opnd_shift),
    .rdata      (mem_rdata),
    .pc         (pc_q),
    .opnd       (opnd_q)
  );

  nyb_acc #(.DATA_W(DATA_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .acc_op   (acc_op),
    .led_op   (led_op),
    .rdata    (mem_rdata),
    .acc      (acc_q),
    .led      (led),
    .acc_zero (acc_zero)
  );

  assign mem_addr  = (addr_sel == ASEL_OPND) ? opnd_q : pc_q;
  assign mem_wdata = acc_q;
  assign mem_we    = store_we;

  assign evt_inc   = (acc_op == ACC_INC);
  assign evt_dec   = (acc_op == ACC_DEC);
  assign evt_load  = (acc_op == ACC_LOAD);
  assign evt_show  = (led_op == LED_SHOW);
  assign evt_blank = (led_op == LED_BLANK);
  assign evt_jump  = pc_load;

endmodule

// File: rtl/nyb_cpu_chk.sv
module nyb_cpu_chk #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [DATA_W-1:0] led,
  input logic [DATA_W-1:0] acc,
  input logic              evt_inc,
  input logic              evt_dec,
  input logic              evt_load,
  input logic              evt_show,
  input logic              evt_blank,
  input logic              evt_jump
);

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (led == '0 && !mem_we && mem_addr == '0)); // R1

  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(evt_inc || evt_dec || evt_load) |=> $stable(acc)); // R2

  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R4

  AST_JUMP_ZERO: assert property (@(posedge clk) disable iff (rst)
    evt_jump |-> (acc == '0)); // R5

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (evt_inc && acc == {DATA_W{1'b1}}) |=> (acc == '0)); // R7

  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (evt_dec && acc == '0) |=> (acc == {DATA_W{1'b1}})); // R8

  AST_LED_SHOW: assert property (@(posedge clk) disable iff (rst)
    evt_show |=> (led == $past(acc))); // R9

  AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(evt_show || evt_blank) |=> $stable(led)); // R9

  AST_LED_BLANK: assert property (@(posedge clk) disable iff (rst)
    evt_blank |=> (led == '0)); // R10

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({evt_inc, evt_dec, evt_load, evt_show, evt_blank, mem_we}) <= 1); // R11

endmodule

bind nyb_cpu nyb_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .led       (led),
  .acc       (acc_q),
  .evt_inc   (evt_inc),
  .evt_dec   (evt_dec),
  .evt_load  (evt_load),
  .evt_show  (evt_show),
  .evt_blank (evt_blank),
  .evt_jump  (evt_jump)
);

// File: tb/nyb_cpu_test.sv
`timescale 1ns/1ps
module nyb_cpu_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mem_addr;
  logic [3:0] mem_rdata;
  logic [3:0] mem_wdata;
  logic       mem_we;
  logic [3:0] led;

  logic [3:0] mem [256];
  logic       wipe_req = 1'b0;
  logic       ld_en = 1'b0;
  logic [7:0] ld_a = '0;
  logic [3:0] ld_d = '0;
  int         wr_count = 0;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  nyb_cpu uut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .led       (led)
  );

  // synchronous memory model with a bench-side loading path
  always @(posedge clk) begin
    if (wipe_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= 4'h0;
      wr_count <= 0;
    end else if (ld_en) begin
      mem[ld_a] <= ld_d;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input int d);
    ld_a = 8'(a); ld_d = 4'(d); ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // load 0xFF (kept zero) then jump to self forever
  task automatic put_halt(input int a);
    put(a, 1); put(a + 1, 4'hF); put(a + 2, 4'hF);
    put(a + 3, 3); put(a + 4, (a + 3) >> 4); put(a + 5, (a + 3) & 15);
  endtask

  task automatic begin_prog();
    rst = 1'b1;
    @(negedge clk);
    wipe_req = 1'b1;
    @(negedge clk);
    wipe_req = 1'b0;
  endtask

  task automatic launch(input int cycles);
    @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_reset();
    begin_prog();
    put(0, 4); put(1, 6); put_halt(2);
    launch(60);
    check("R9 led shows acc before reset", led, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 led cleared", led, 0);
    check("R1 no write", mem_we, 0);
    check("R1 address zero", mem_addr, 0);
    launch(0);
    check("R1 first fetch at zero", mem_addr, 0);
    check("R1 led zero after release", led, 0);
  endtask

  task automatic t_nop();
    begin_prog();
    put(0, 4);
    for (int k = 0; k < 8; k++) put(1 + k, 8 + k);
    put(9, 0); put(10, 6); put_halt(11);
    launch(200);
    check("R2 acc untouched by nop/unassigned", led, 1);
    check("R2 no memory writes", wr_count, 0);
  endtask

  task automatic t_load();
    begin_prog();
    put(0, 1); put(1, 3); put(2, 4'hC); put(3, 6); put_halt(4);
    put(8'h3C, 9); put(8'hC3, 5);
    launch(200);
    check("R3 load high nybble first", led, 9);
  endtask

  task automatic t_store();
    begin_prog();
    put(0, 1); put(1, 4); put(2, 0); put(3, 4);
    put(4, 2); put(5, 8); put(6, 1); put_halt(7);
    put(8'h40, 7);
    launch(200);
    check("R4 stored value", mem[8'h81], 8);
    check("R4 swapped address untouched", mem[8'h18], 0);
    check("R4 single write", wr_count, 1);
  endtask

  task automatic t_jump_taken();
    begin_prog();
    put(0, 3); put(1, 2); put(2, 0); put(3, 4); put(4, 6); put_halt(5);
    put(8'h20, 5); put(8'h21, 6); put_halt(8'h22);
    launch(200);
    check("R5 jump taken on zero / R8 dec wraps", led, 15);
  endtask

  task automatic t_jump_not();
    begin_prog();
    put(0, 4); put(1, 3); put(2, 2); put(3, 0); put(4, 6); put_halt(5);
    put(8'h20, 7);
    launch(200);
    check("R6 jump not taken on non-zero", led, 1);
  endtask

  task automatic t_wrap();
    begin_prog();
    for (int k = 0; k < 17; k++) put(k, 4);
    put(17, 6); put_halt(18);
    launch(200);
    check("R7 increment wraps 15 to 0", led, 1);
    begin_prog();
    put(0, 5); put(1, 5); put(2, 6); put_halt(3);
    launch(200);
    check("R8 decrement wraps 0 to 15", led, 14);
  endtask

  task automatic t_led();
    begin_prog();
    put(0, 4); put(1, 4); put(2, 4); put(3, 6); put(4, 4); put_halt(5);
    launch(200);
    check("R9 led holds while acc moves", led, 3);
    begin_prog();
    put(0, 4); put(1, 6); put(2, 7); put_halt(3);
    launch(4);
    check("R9 show at fourth edge", led, 1);
    repeat (2) @(negedge clk);
    check("R10 blank clears led", led, 0);
  endtask

  task automatic t_timing();
    begin_prog();
    put(0, 4); put(1, 4); put(2, 6); put_halt(3);
    launch(5);
    check("R11 led unchanged before sixth edge", led, 0);
    @(negedge clk);
    check("R11 led updated at sixth edge", led, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_nop();
    t_load();
    t_store();
    t_jump_taken();
    t_jump_not();
    t_wrap();
    t_led();
    t_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule